// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (one clock line, one open-drain data line) that holds a small bank of 8-bit registers. Other on-chip logic reads these registers to set up clock generation. The bus lines are oversampled by the system clock. The slave answers to one fixed 7-bit address. It supports four transfer kinds: a single register written or read at an offset that the command byte names, and a block written or read starting at offset 0, where each block carries a byte-count byte.

A write transfer sends three things in turn: the address with the direction bit clear, a command byte, and then the payload. For a read, the master sends the command in a write phase, issues a repeated start, and then sends the address with the direction bit set. The slave then drives data onto SDA through an output enable, most significant bit first. Register 0 is a read-only identity byte. Registers 1 and 2 are writable configuration bytes, and both drive output ports.

Top module: `cfg_twowire_slave`

## Requirements
- R1: After reset, cfg_en_o is 0xF7 and cfg_spread_o is 0x00. Register 0 reads back 0x1F.
- R2: An address byte whose upper seven bits equal 1101001 (0xD2 for a write, 0xD3 for a read) is acknowledged by SDA held low during the ninth clock. Any other address is not acknowledged. After a mismatch, the slave drives nothing and changes nothing until the next start.
- R3: A command byte with bit 7 = 1 selects single-register mode, and bits 6:0 give the offset. One data byte then written is acknowledged and stored at that offset.
- R4: A command byte of 0x00 selects block mode. The next byte is a count N. Up to N data bytes follow and are stored at offsets 0, 1, 2, … in order, each acknowledged. Data bytes beyond N are not acknowledged and are not stored.
- R5: A stop after any complete data byte of a block write ends the transfer. Bytes already acknowledged stay stored.
- R6: A single-register read (command 0x80|offset, repeated start, 0xD3) returns the register at that offset, most significant bit first.
- R7: A block read (command 0x00, repeated start, 0xD3) first returns the register count (3), then registers from offset 0 upward for as long as the master acknowledges. After the master's NACK, the slave releases SDA.
- R8: Writes to offset 0 or to offsets of 3 or more are acknowledged but change nothing. Reads of offsets of 3 or more return 0x00.
- R9: The slave asserts its SDA drive only while SCL is low, and keeps its SDA drive unchanged while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| cfg_en_o | output | 8 | Contents of register 1 |
| cfg_spread_o | output | 8 | Contents of register 2 (bits 2:0 select the spread setting) |

## Verification
A corrupted phase, bit counter or pointer shows up at the ports within a single byte time. It appears as an acknowledge in the wrong clock, a read byte shifted by one bit, or a register value landing one offset away. A lost count or mode bit shows up only on the next data byte, as a NACK where an ACK was due or the reverse. The configuration outputs are therefore compared with a reference on every clock. Every acknowledge and every read bit is also checked in its own bus clock.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK,
        ST_WAIT
    } twi_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } twi_ph_e;
endpackage

// File: rtl/twi_sync_edge.sv
module twi_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe_q[STAGES-1];
    assign sda_s    = sda_pipe_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev_q;
    assign scl_fall = ~scl_s & scl_prev_q;
    assign start_ev = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_ev  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank #(
    parameter int                  NREG     = 3,
    parameter int                  OFFW     = 7,
    parameter logic [7:0]          ID_VALUE = 8'h1F,
    parameter logic [NREG*8-1:0]   RST_VEC  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFFW-1:0]   waddr,
    input  logic [7:0]        wdata,
    input  logic [OFFW-1:0]   raddr,
    output logic [7:0]        rdata,
    output logic [NREG*8-1:0] regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_ro
            assign regs_o[7:0] = ID_VALUE;
        end else begin : g_rw
            logic [7:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (we && (waddr == OFFW'(g))) val_d = wdata;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= RST_VEC[g*8 +: 8];
                else        val_q <= val_d;
            end
            assign regs_o[g*8 +: 8] = val_q;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == OFFW'(i)) rdata = regs_o[i*8 +: 8];
        end
    end
endmodule

// File: rtl/cfg_twowire_slave.sv
module cfg_twowire_slave
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         NREG      = 3,
    parameter int         OFFW      = 7,
    parameter logic [7:0] ID_VALUE  = 8'h1F,
    parameter logic [7:0] EN_RST    = 8'hF7,
    parameter logic [7:0] SPR_RST   = 8'h00,
    parameter int         SYNC_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] cfg_en_o,
    output logic [7:0] cfg_spread_o
);
    localparam logic [7:0]        CNT_BYTE = 8'(NREG);
    localparam logic [NREG*8-1:0] RST_VEC  = (NREG*8)'({SPR_RST, EN_RST, 8'h00});

    typedef struct packed {
        twi_st_e         st;
        twi_ph_e         ph;
        logic [2:0]      bitc;
        logic [7:0]      sh;
        logic            rw;
        logic            blk;
        logic            need_cnt;
        logic            full;
        logic            oe;
        logic [OFFW-1:0] ptr;
        logic [7:0]      left;
    } ctl_t;

    ctl_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic we;
    logic [7:0] rd_data, tx_byte;
    logic [NREG*8-1:0] regs;
    logic ignoring;

    twi_sync_edge #(.STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    twi_regbank #(.NREG(NREG), .OFFW(OFFW), .ID_VALUE(ID_VALUE), .RST_VEC(RST_VEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(q.ptr), .wdata(q.sh),
        .raddr(q.ptr), .rdata(rd_data), .regs_o(regs)
    );

    assign tx_byte = q.need_cnt ? CNT_BYTE : rd_data;

    always_comb begin
        n  = q;
        we = 1'b0;
        if (start_ev) begin
            n.st   = ST_RX;
            n.ph   = PH_ADDR;
            n.bitc = '0;
            n.full = 1'b0;
            n.oe   = 1'b0;
        end else if (stop_ev) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        n.sh   = {q.sh[6:0], sda_s};
                        n.bitc = q.bitc + 3'd1;
                        n.full = (q.bitc == 3'd7);
                    end else if (scl_fall && q.full) begin
                        n.full = 1'b0;
                        n.st   = ST_RXACK;
                        n.oe   = 1'b1;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[7:1] != DEV_ADDR) begin
                                    n.st = ST_WAIT;
                                    n.oe = 1'b0;
                                end else begin
                                    n.rw       = q.sh[0];
                                    n.need_cnt = q.blk;
                                    if (!q.sh[0]) n.ph = PH_CMD;
                                end
                            end
                            PH_CMD: begin
                                n.blk  = ~q.sh[7];
                                n.ptr  = q.sh[7] ? q.sh[OFFW-1:0] : '0;
                                n.left = q.sh[7] ? 8'd1 : 8'd0;
                                n.ph   = q.sh[7] ? PH_DATA : PH_CNT;
                            end
                            PH_CNT: begin
                                n.left = q.sh;
                                n.ph   = PH_DATA;
                            end
                            default: begin
                                if (q.left == 8'd0) begin
                                    n.st = ST_WAIT;
                                    n.oe = 1'b0;
                                end else begin
                                    we     = 1'b1;
                                    n.ptr  = q.ptr + 1'b1;
                                    n.left = q.left - 8'd1;
                                end
                            end
                        endcase
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        n.oe   = 1'b0;
                        n.bitc = '0;
                        n.st   = ST_RX;
                        if (q.ph == PH_ADDR && q.rw) begin
                            n.st       = ST_TX;
                            n.sh       = tx_byte;
                            n.oe       = ~tx_byte[7];
                            n.need_cnt = 1'b0;
                            if (!q.need_cnt) n.ptr = q.ptr + 1'b1;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bitc == 3'd7) begin
                            n.oe   = 1'b0;
                            n.st   = ST_TXACK;
                            n.full = 1'b0;
                        end else begin
                            n.bitc = q.bitc + 3'd1;
                            n.sh   = {q.sh[6:0], 1'b0};
                            n.oe   = ~q.sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        n.full = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.full) begin
                            n.st   = ST_TX;
                            n.bitc = '0;
                            n.sh   = tx_byte;
                            n.oe   = ~tx_byte[7];
                            n.full = 1'b0;
                            n.ptr  = q.ptr + 1'b1;
                        end else begin
                            n.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: PH_ADDR, default: '0};
        end else begin
            q <= n;
        end
    end

    assign ignoring     = (q.st == ST_WAIT);
    assign sda_oe_o     = q.oe;
    assign cfg_en_o     = regs[15:8];
    assign cfg_spread_o = regs[23:16];
endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       scl_fall,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       ignoring,
    input logic       sda_oe_o,
    input logic [7:0] cfg_en_o,
    input logic [7:0] cfg_spread_o
);
    AST_RESET_VALUES: assert property (@(posedge clk) $rose(rst_n) |-> (cfg_en_o == 8'hF7 && cfg_spread_o == 8'h00)); // R1
    AST_MISMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ignoring |-> !sda_oe_o); // R2
    AST_CFG_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable({cfg_en_o, cfg_spread_o}) |-> $past(scl_fall)); // R3
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $past(stop_ev) |-> !sda_oe_o); // R7
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $past(start_ev) |-> !sda_oe_o); // R2
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe_o) |-> !scl_s); // R9
endmodule

bind cfg_twowire_slave twi_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .ignoring(ignoring),
    .sda_oe_o(sda_oe_o), .cfg_en_o(cfg_en_o), .cfg_spread_o(cfg_spread_o)
);

// File: tb/cfg_twowire_slave_tb.sv
module cfg_twowire_slave_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [7:0] cfg_en, cfg_spread;
    logic sda_line;
    int vecs = 0;
    int bad = 0;
    bit done = 1'b0;
    int exp_reg [0:2];
    int pend_idx = -1;
    int pend_val = 0;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    cfg_twowire_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .cfg_en_o(cfg_en), .cfg_spread_o(cfg_spread)
    );

    task automatic chk(input string r, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // reference registers compared on every clock (R3 R4 R5 R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 cfg_en per clock", int'(cfg_en), exp_reg[1]);
            chk("R4 cfg_spread per clock", int'(cfg_spread), exp_reg[2]);
        end
    end

    task automatic wait_clk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic scl_lo();
        @(negedge clk) m_scl = 1'b0;
        repeat (3) @(posedge clk);
        if (pend_idx >= 0) begin
            exp_reg[pend_idx] = pend_val;
            pend_idx = -1;
        end
        wait_clk(5);
    endtask

    task automatic put_bit(input bit b);
        logic oe_a;
        @(negedge clk) m_sda = b;
        wait_clk(2);
        @(negedge clk) m_scl = 1'b1;
        wait_clk(1);
        oe_a = sda_oe;
        wait_clk(7);
        chk("R9 drive stable while SCL high", int'(sda_oe), int'(oe_a));
        scl_lo();
    endtask

    task automatic get_bit(output bit b);
        logic oe_a;
        @(negedge clk) m_sda = 1'b1;
        wait_clk(2);
        @(negedge clk) m_scl = 1'b1;
        wait_clk(1);
        oe_a = sda_oe;
        wait_clk(3);
        b = sda_line;
        wait_clk(4);
        chk("R9 drive stable while SCL high", int'(sda_oe), int'(oe_a));
        scl_lo();
    endtask

    task automatic wr_byte(input logic [7:0] v, input bit exp_ack, input int idx, input string r);
        bit a;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0 && idx >= 0) begin
                pend_idx = idx;
                pend_val = int'(v);
            end
            put_bit(v[i]);
        end
        get_bit(a);
        chk(r, int'(!a), int'(exp_ack));
    endtask

    task automatic rd_byte(output logic [7:0] v, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    task automatic start_c();
        @(negedge clk) m_sda = 1'b1;
        wait_clk(4);
        @(negedge clk) m_scl = 1'b1;
        wait_clk(8);
        @(negedge clk) m_sda = 1'b0;
        wait_clk(8);
        scl_lo();
    endtask

    task automatic stop_c();
        @(negedge clk) m_sda = 1'b0;
        wait_clk(4);
        @(negedge clk) m_scl = 1'b1;
        wait_clk(8);
        @(negedge clk) m_sda = 1'b1;
        wait_clk(8);
    endtask

    task automatic byte_write(input logic [7:0] off, input logic [7:0] v, input string r);
        int idx;
        idx = (off >= 8'd1 && off <= 8'd2) ? int'(off) : -1;
        start_c();
        wr_byte(8'hD2, 1'b1, -1, "R2 write address ack");
        wr_byte(8'h80 | off, 1'b1, -1, "R3 command ack");
        wr_byte(v, 1'b1, idx, r);
        stop_c();
    endtask

    task automatic byte_read(input logic [7:0] off, input int exp, input string r);
        logic [7:0] v;
        start_c();
        wr_byte(8'hD2, 1'b1, -1, "R2 write address ack");
        wr_byte(8'h80 | off, 1'b1, -1, "R6 command ack");
        start_c();
        wr_byte(8'hD3, 1'b1, -1, "R2 read address ack");
        rd_byte(v, 1'b0);
        chk(r, int'(v), exp);
        chk("R7 released after master NACK", int'(sda_oe), 0);
        stop_c();
    endtask

    initial begin
        logic [7:0] v;
        exp_reg[0] = 32'h1F;
        exp_reg[1] = 32'hF7;
        exp_reg[2] = 32'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R1 reset cfg_en", int'(cfg_en), 32'hF7);
        chk("R1 reset cfg_spread", int'(cfg_spread), 32'h00);
        chk("R1 idle no drive", int'(sda_oe), 0);

        byte_read(8'h00, 32'h1F, "R1 identity byte");
        byte_write(8'h02, 8'h06, "R3 byte write ack");
        byte_read(8'h02, 32'h06, "R6 byte read MSB first");
        byte_read(8'h01, 32'hF7, "R6 byte read offset 1");

        // block write: count 3, then one surplus byte
        start_c();
        wr_byte(8'hD2, 1'b1, -1, "R2 address ack");
        wr_byte(8'h00, 1'b1, -1, "R4 block command ack");
        wr_byte(8'h03, 1'b1, -1, "R4 count ack");
        wr_byte(8'hAA, 1'b1, -1, "R8 read-only offset ack");
        wr_byte(8'h5A, 1'b1, 1, "R4 data 1 ack");
        wr_byte(8'h03, 1'b1, 2, "R4 data 2 ack");
        wr_byte(8'h77, 1'b0, -1, "R4 surplus byte NACK");
        stop_c();
        chk("R4 block result reg1", int'(cfg_en), 32'h5A);
        chk("R4 block result reg2", int'(cfg_spread), 32'h03);

        // block write stopped early
        start_c();
        wr_byte(8'hD2, 1'b1, -1, "R2 address ack");
        wr_byte(8'h00, 1'b1, -1, "R5 block command ack");
        wr_byte(8'h03, 1'b1, -1, "R5 count ack");
        wr_byte(8'h00, 1'b1, -1, "R5 data 0 ack");
        wr_byte(8'h3C, 1'b1, 1, "R5 data 1 ack");
        stop_c();
        chk("R5 partial block kept", int'(cfg_en), 32'h3C);
        chk("R5 untouched tail", int'(cfg_spread), 32'h03);

        // address mismatch
        start_c();
        wr_byte(8'hA4, 1'b0, -1, "R2 mismatch NACK");
        wr_byte(8'h82, 1'b0, -1, "R2 ignored after mismatch");
        wr_byte(8'hFF, 1'b0, -1, "R2 ignored data");
        stop_c();
        chk("R2 no change after mismatch", int'(cfg_spread), 32'h03);

        // ignored offsets
        byte_write(8'h05, 8'h99, "R8 out-of-range write ack");
        byte_write(8'h00, 8'h00, "R8 read-only write ack");
        byte_read(8'h05, 32'h00, "R8 out-of-range read");
        byte_read(8'h00, 32'h1F, "R8 read-only unchanged");

        // block read
        start_c();
        wr_byte(8'hD2, 1'b1, -1, "R2 address ack");
        wr_byte(8'h00, 1'b1, -1, "R7 block command ack");
        start_c();
        wr_byte(8'hD3, 1'b1, -1, "R7 read address ack");
        rd_byte(v, 1'b1);
        chk("R7 count byte", int'(v), 3);
        rd_byte(v, 1'b1);
        chk("R7 offset 0", int'(v), 32'h1F);
        rd_byte(v, 1'b1);
        chk("R7 offset 1", int'(v), 32'h3C);
        rd_byte(v, 1'b1);
        chk("R7 offset 2", int'(v), 32'h03);
        rd_byte(v, 1'b0);
        chk("R8 past last register", int'(v), 0);
        chk("R7 released after NACK", int'(sda_oe), 0);
        stop_c();

        wait_clk(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            bad++;
            vecs++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end
endmodule